// File: doc/BRIEF.md
# Host PIO to AXI4-Lite Bridge

This block sits behind a PCIe endpoint's request decoder. It turns host memory-mapped reads and writes aimed at the register window into single AXI4-Lite manager transactions toward user control and status registers, and no DMA engine is involved. Each request arrives on a valid/ready port. That port carries a direction flag, the BAR index, the function identity (virtual-function flag, physical function number, virtual function number), a byte offset, a byte length, 64-bit write data and a tag.

The manager address places the function identity above the offset within the window: the virtual-function flag is the top bit, then the PF number, then the VF number, and the offset fills the low bits. Only one access is in flight at a time. The result goes back on a completion port with the captured tag, the read data and a status code. A request for the wrong window, a size other than 8 bytes or an unaligned offset never reaches AXI. It completes at once with an unsupported status.

Top module: `pio_axil_bridge`

## Requirements
- R1: A request whose BAR index is not TARGET_BAR (default 2) produces no AXI valid and completes in the cycle after acceptance with status 1 (unsupported) and zero read data.
- R2: A request whose byte length is not exactly 8 completes with status 1 and produces no AXI traffic.
- R3: A request whose offset bits [2:0] are not all zero completes with status 1 and zero read data, with no AXI traffic.
- R4: The AXI address of a forwarded access equals {vf_active, pf, vf, offset}: the flag in the MSB, then PF_W bits of PF, then VF_W bits of VF, then OFF_W = log2(BAR_BYTES) offset bits.
- R5: A write raises AWVALID and WVALID in the same cycle, the one after acceptance, with WSTRB = 8'hFF, WDATA equal to the request data and AWPROT = 0.
- R6: AWVALID and WVALID each stay high, with stable payload, until their own handshake and then drop on their own. BREADY is raised only after both have completed.
- R7: A read raises ARVALID (ARPROT = 0) until ARREADY. The RDATA returned is passed to the completion with the request's tag.
- R8: An OKAY response (2'b00) gives completion status 0. Any other BRESP or RRESP gives status 2 (error), with the captured tag.
- R9: Request ready is low from acceptance until the completion is accepted, so a request offered in that window is not taken.
- R10: While completion valid is high and completion ready is low, the completion valid, tag, data and status stay unchanged.
- R11: After reset, request ready is high and every AXI valid, BREADY, RREADY and completion valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Request ready |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_bar_i | input | BAR_W | BAR index hit by the request |
| req_vf_active_i | input | 1 | Request comes from a virtual function |
| req_pf_i | input | PF_W | Physical function number |
| req_vf_i | input | VF_W | Virtual function number |
| req_off_i | input | OFF_W | Byte offset inside the window |
| req_len_i | input | LEN_W | Access length in bytes |
| req_wdata_i | input | DW | Write data |
| req_tag_i | input | TAG_W | Request tag |
| m_awvalid_o | output | 1 | Write address valid |
| m_awready_i | input | 1 | Write address ready |
| m_awaddr_o | output | AW | Write address |
| m_awprot_o | output | 3 | Write protection, zero |
| m_wvalid_o | output | 1 | Write data valid |
| m_wready_i | input | 1 | Write data ready |
| m_wdata_o | output | DW | Write data |
| m_wstrb_o | output | DW/8 | Byte strobes, all ones |
| m_bvalid_i | input | 1 | Write response valid |
| m_bready_o | output | 1 | Write response ready |
| m_bresp_i | input | 2 | Write response code |
| m_arvalid_o | output | 1 | Read address valid |
| m_arready_i | input | 1 | Read address ready |
| m_araddr_o | output | AW | Read address |
| m_arprot_o | output | 3 | Read protection, zero |
| m_rvalid_i | input | 1 | Read data valid |
| m_rready_o | output | 1 | Read data ready |
| m_rdata_i | input | DW | Read data |
| m_rresp_i | input | 2 | Read response code |
| cpl_valid_o | output | 1 | Completion valid |
| cpl_ready_i | input | 1 | Completion ready |
| cpl_tag_o | output | TAG_W | Captured tag |
| cpl_rdata_o | output | DW | Read data, zero for writes and rejects |
| cpl_status_o | output | 2 | 0 OK, 1 unsupported, 2 error |

## Verification
On every cycle the assertions check the following. The AW, W, AR and completion channels hold their valid and payload until the handshake. AWVALID and WVALID rise together. Acceptance drops request ready. A rejected request goes straight to an unsupported completion with no AXI valid, and forwarded addresses stay 8-byte aligned. Only the bench's scenarios can show the rest. That covers the exact address packing for different function identities, each rejection cause on its own, how response codes map to status, read data passing through, split AW/W handshakes, and a second request being refused while the first is still open.

// File: rtl/pio_pkg.sv
package pio_pkg;
  typedef enum logic [1:0] {
    CPL_OK  = 2'd0,
    CPL_UR  = 2'd1,
    CPL_ERR = 2'd2
  } cpl_status_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WR,
    ST_RD,
    ST_CPL
  } eng_state_e;

  localparam logic [1:0] RESP_OKAY = 2'b00;
endpackage

// File: rtl/pio_addr_map.sv
module pio_addr_map #(
  parameter int BAR_W      = 3,
  parameter int TARGET_BAR = 2,
  parameter int PF_W       = 2,
  parameter int VF_W       = 2,
  parameter int OFF_W      = 22,
  parameter int LEN_W      = 8,
  parameter int DW         = 64,
  localparam int AW        = 1 + PF_W + VF_W + OFF_W
) (
  input  logic [BAR_W-1:0] bar_i,
  input  logic             vf_active_i,
  input  logic [PF_W-1:0]  pf_i,
  input  logic [VF_W-1:0]  vf_i,
  input  logic [OFF_W-1:0] off_i,
  input  logic [LEN_W-1:0] len_i,
  output logic [AW-1:0]    addr_o,
  output logic             ok_o
);
  localparam int BYTES = DW / 8;
  localparam int ALIGN = $clog2(BYTES);

  logic bar_hit, len_hit, aligned;

  assign bar_hit = (bar_i == BAR_W'(TARGET_BAR));
  assign len_hit = (len_i == LEN_W'(BYTES));
  assign aligned = (off_i[ALIGN-1:0] == '0);
  assign ok_o    = bar_hit && len_hit && aligned;
  assign addr_o  = {vf_active_i, pf_i, vf_i, off_i};
endmodule

// File: rtl/pio_axil_engine.sv
module pio_axil_engine
  import pio_pkg::*;
#(
  parameter int AW    = 27,
  parameter int DW    = 64,
  parameter int TAG_W = 8,
  localparam int SW   = DW / 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  output logic             req_ready_o,
  input  logic             req_write_i,
  input  logic             req_ok_i,
  input  logic [AW-1:0]    req_addr_i,
  input  logic [DW-1:0]    req_wdata_i,
  input  logic [TAG_W-1:0] req_tag_i,
  output logic             m_awvalid_o,
  input  logic             m_awready_i,
  output logic [AW-1:0]    m_awaddr_o,
  output logic [2:0]       m_awprot_o,
  output logic             m_wvalid_o,
  input  logic             m_wready_i,
  output logic [DW-1:0]    m_wdata_o,
  output logic [SW-1:0]    m_wstrb_o,
  input  logic             m_bvalid_i,
  output logic             m_bready_o,
  input  logic [1:0]       m_bresp_i,
  output logic             m_arvalid_o,
  input  logic             m_arready_i,
  output logic [AW-1:0]    m_araddr_o,
  output logic [2:0]       m_arprot_o,
  input  logic             m_rvalid_i,
  output logic             m_rready_o,
  input  logic [DW-1:0]    m_rdata_i,
  input  logic [1:0]       m_rresp_i,
  output logic             cpl_valid_o,
  input  logic             cpl_ready_i,
  output logic [TAG_W-1:0] cpl_tag_o,
  output logic [DW-1:0]    cpl_rdata_o,
  output logic [1:0]       cpl_status_o
);
  eng_state_e       state_q;
  logic             aw_q, w_q, ar_q;
  logic [AW-1:0]    addr_q;
  logic [DW-1:0]    wdata_q, rdata_q;
  logic [TAG_W-1:0] tag_q;
  cpl_status_e      status_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      aw_q     <= 1'b0;
      w_q      <= 1'b0;
      ar_q     <= 1'b0;
      addr_q   <= '0;
      wdata_q  <= '0;
      rdata_q  <= '0;
      tag_q    <= '0;
      status_q <= CPL_OK;
    end else begin
      unique case (state_q)
        ST_IDLE: if (req_valid_i) begin
          tag_q   <= req_tag_i;
          addr_q  <= req_addr_i;
          wdata_q <= req_wdata_i;
          rdata_q <= '0;
          if (!req_ok_i) begin
            status_q <= CPL_UR;
            state_q  <= ST_CPL;
          end else if (req_write_i) begin
            aw_q    <= 1'b1;
            w_q     <= 1'b1;
            state_q <= ST_WR;
          end else begin
            ar_q    <= 1'b1;
            state_q <= ST_RD;
          end
        end
        ST_WR: begin
          if (aw_q && m_awready_i) aw_q <= 1'b0;
          if (w_q && m_wready_i)   w_q  <= 1'b0;
          if (m_bready_o && m_bvalid_i) begin
            status_q <= (m_bresp_i == RESP_OKAY) ? CPL_OK : CPL_ERR;
            state_q  <= ST_CPL;
          end
        end
        ST_RD: begin
          if (ar_q && m_arready_i) ar_q <= 1'b0;
          if (m_rready_o && m_rvalid_i) begin
            rdata_q  <= m_rdata_i;
            status_q <= (m_rresp_i == RESP_OKAY) ? CPL_OK : CPL_ERR;
            state_q  <= ST_CPL;
          end
        end
        ST_CPL: if (cpl_ready_i) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready_o  = (state_q == ST_IDLE);
  assign m_awvalid_o  = aw_q;
  assign m_awaddr_o   = addr_q;
  assign m_awprot_o   = 3'b000;
  assign m_wvalid_o   = w_q;
  assign m_wdata_o    = wdata_q;
  assign m_wstrb_o    = '1;
  // B only after both address and data are gone
  assign m_bready_o   = (state_q == ST_WR) && !aw_q && !w_q;
  assign m_arvalid_o  = ar_q;
  assign m_araddr_o   = addr_q;
  assign m_arprot_o   = 3'b000;
  assign m_rready_o   = (state_q == ST_RD) && !ar_q;
  assign cpl_valid_o  = (state_q == ST_CPL);
  assign cpl_tag_o    = tag_q;
  assign cpl_rdata_o  = rdata_q;
  assign cpl_status_o = status_q;

  assert_aw_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    m_awvalid_o && !m_awready_i |=> m_awvalid_o && $stable(m_awaddr_o));
  assert_w_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    m_wvalid_o && !m_wready_i |=> m_wvalid_o && $stable(m_wdata_o));
  assert_ar_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    m_arvalid_o && !m_arready_i |=> m_arvalid_o && $stable(m_araddr_o));
  assert_aw_w_pair_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(m_awvalid_o) |-> $rose(m_wvalid_o));
  assert_single_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_ready_o |=> !req_ready_o);
  assert_cpl_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpl_valid_o && !cpl_ready_i |=> cpl_valid_o && $stable(cpl_tag_o)
      && $stable(cpl_rdata_o) && $stable(cpl_status_o));
endmodule

// File: rtl/pio_axil_bridge.sv
module pio_axil_bridge #(
  parameter int NUM_PF     = 4,
  parameter int NUM_VF     = 4,
  parameter int BAR_BYTES  = 4194304,
  parameter int TARGET_BAR = 2,
  parameter int BAR_W      = 3,
  parameter int LEN_W      = 8,
  parameter int TAG_W      = 8,
  parameter int DW         = 64,
  localparam int PF_W      = (NUM_PF > 1) ? $clog2(NUM_PF) : 1,
  localparam int VF_W      = (NUM_VF > 1) ? $clog2(NUM_VF) : 1,
  localparam int OFF_W     = $clog2(BAR_BYTES),
  localparam int AW        = 1 + PF_W + VF_W + OFF_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  output logic             req_ready_o,
  input  logic             req_write_i,
  input  logic [BAR_W-1:0] req_bar_i,
  input  logic             req_vf_active_i,
  input  logic [PF_W-1:0]  req_pf_i,
  input  logic [VF_W-1:0]  req_vf_i,
  input  logic [OFF_W-1:0] req_off_i,
  input  logic [LEN_W-1:0] req_len_i,
  input  logic [DW-1:0]    req_wdata_i,
  input  logic [TAG_W-1:0] req_tag_i,
  output logic             m_awvalid_o,
  input  logic             m_awready_i,
  output logic [AW-1:0]    m_awaddr_o,
  output logic [2:0]       m_awprot_o,
  output logic             m_wvalid_o,
  input  logic             m_wready_i,
  output logic [DW-1:0]    m_wdata_o,
  output logic [DW/8-1:0]  m_wstrb_o,
  input  logic             m_bvalid_i,
  output logic             m_bready_o,
  input  logic [1:0]       m_bresp_i,
  output logic             m_arvalid_o,
  input  logic             m_arready_i,
  output logic [AW-1:0]    m_araddr_o,
  output logic [2:0]       m_arprot_o,
  input  logic             m_rvalid_i,
  output logic             m_rready_o,
  input  logic [DW-1:0]    m_rdata_i,
  input  logic [1:0]       m_rresp_i,
  output logic             cpl_valid_o,
  input  logic             cpl_ready_i,
  output logic [TAG_W-1:0] cpl_tag_o,
  output logic [DW-1:0]    cpl_rdata_o,
  output logic [1:0]       cpl_status_o
);
  logic [AW-1:0] map_addr;
  logic          map_ok;

  pio_addr_map #(
    .BAR_W(BAR_W), .TARGET_BAR(TARGET_BAR), .PF_W(PF_W), .VF_W(VF_W),
    .OFF_W(OFF_W), .LEN_W(LEN_W), .DW(DW)
  ) u_map (
    .bar_i(req_bar_i), .vf_active_i(req_vf_active_i), .pf_i(req_pf_i),
    .vf_i(req_vf_i), .off_i(req_off_i), .len_i(req_len_i),
    .addr_o(map_addr), .ok_o(map_ok)
  );

  pio_axil_engine #(.AW(AW), .DW(DW), .TAG_W(TAG_W)) u_eng (
    .clk_i, .rst_ni,
    .req_valid_i, .req_ready_o, .req_write_i,
    .req_ok_i(map_ok), .req_addr_i(map_addr),
    .req_wdata_i, .req_tag_i,
    .m_awvalid_o, .m_awready_i, .m_awaddr_o, .m_awprot_o,
    .m_wvalid_o, .m_wready_i, .m_wdata_o, .m_wstrb_o,
    .m_bvalid_i, .m_bready_o, .m_bresp_i,
    .m_arvalid_o, .m_arready_i, .m_araddr_o, .m_arprot_o,
    .m_rvalid_i, .m_rready_o, .m_rdata_i, .m_rresp_i,
    .cpl_valid_o, .cpl_ready_i, .cpl_tag_o, .cpl_rdata_o, .cpl_status_o
  );

  // R1 R2 R3: a rejected request goes straight to an unsupported completion
  assert_reject_no_axi_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_ready_o && !map_ok |=>
      cpl_valid_o && !m_awvalid_o && !m_arvalid_o && cpl_status_o == 2'd1);
  assert_aligned_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    m_awvalid_o || m_arvalid_o |-> m_awaddr_o[2:0] == 3'b000);
endmodule

// File: tb/sim_pio_axil_bridge.sv
`timescale 1ns/1ps
module sim_pio_axil_bridge;
  typedef struct packed {
    logic        wr;
    logic [2:0]  bar;
    logic        vfa;
    logic [1:0]  pf;
    logic [1:0]  vf;
    logic [21:0] off;
    logic [7:0]  len;
    logic [63:0] wdata;
    logic [7:0]  tag;
    logic [1:0]  resp;
    logic [63:0] rdata;
    logic [1:0]  exp_st;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VEC [0:NV-1] = '{
    '{1'b1, 3'd2, 1'b0, 2'd1, 2'd0, 22'h000010, 8'd8, 64'h1122334455667788, 8'h01, 2'b00, 64'h0, 2'd0},
    '{1'b0, 3'd2, 1'b1, 2'd2, 2'd3, 22'h3FFFF8, 8'd8, 64'h0, 8'h02, 2'b00, 64'hDEADBEEFCAFEF00D, 2'd0},
    '{1'b1, 3'd2, 1'b0, 2'd0, 2'd1, 22'h000100, 8'd8, 64'hA5A5A5A5A5A5A5A5, 8'h03, 2'b10, 64'h0, 2'd2},
    '{1'b0, 3'd2, 1'b0, 2'd3, 2'd0, 22'h000040, 8'd8, 64'h0, 8'h04, 2'b11, 64'h0123456789ABCDEF, 2'd2},
    '{1'b0, 3'd0, 1'b0, 2'd0, 2'd0, 22'h000008, 8'd8, 64'h0, 8'h05, 2'b00, 64'h0, 2'd1},
    '{1'b1, 3'd2, 1'b0, 2'd0, 2'd0, 22'h000008, 8'd4, 64'hFFFF, 8'h06, 2'b00, 64'h0, 2'd1},
    '{1'b0, 3'd2, 1'b0, 2'd1, 2'd1, 22'h000004, 8'd8, 64'h0, 8'h07, 2'b00, 64'h0, 2'd1},
    '{1'b0, 3'd3, 1'b1, 2'd0, 2'd0, 22'h000000, 8'd16, 64'h0, 8'h08, 2'b00, 64'h0, 2'd1},
    '{1'b1, 3'd2, 1'b1, 2'd3, 2'd3, 22'h200000, 8'd8, 64'h0F0E0D0C0B0A0908, 8'h09, 2'b00, 64'h0, 2'd0}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        req_valid = 0, req_write = 0, req_vfa = 0;
  logic [2:0]  req_bar = 0;
  logic [1:0]  req_pf = 0, req_vf = 0;
  logic [21:0] req_off = 0;
  logic [7:0]  req_len = 0, req_tag = 0;
  logic [63:0] req_wdata = 0;
  logic        req_ready;
  logic        awvalid, awready = 0, wvalid, wready = 0, bvalid = 0, bready;
  logic        arvalid, arready = 0, rvalid = 0, rready;
  logic [26:0] awaddr, araddr;
  logic [2:0]  awprot, arprot;
  logic [63:0] wdata, rdata = 0;
  logic [7:0]  wstrb;
  logic [1:0]  bresp = 0, rresp = 0;
  logic        cpl_valid, cpl_ready = 0;
  logic [7:0]  cpl_tag;
  logic [63:0] cpl_rdata;
  logic [1:0]  cpl_status;

  pio_axil_bridge u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_write_i(req_write),
    .req_bar_i(req_bar), .req_vf_active_i(req_vfa), .req_pf_i(req_pf),
    .req_vf_i(req_vf), .req_off_i(req_off), .req_len_i(req_len),
    .req_wdata_i(req_wdata), .req_tag_i(req_tag),
    .m_awvalid_o(awvalid), .m_awready_i(awready), .m_awaddr_o(awaddr), .m_awprot_o(awprot),
    .m_wvalid_o(wvalid), .m_wready_i(wready), .m_wdata_o(wdata), .m_wstrb_o(wstrb),
    .m_bvalid_i(bvalid), .m_bready_o(bready), .m_bresp_i(bresp),
    .m_arvalid_o(arvalid), .m_arready_i(arready), .m_araddr_o(araddr), .m_arprot_o(arprot),
    .m_rvalid_i(rvalid), .m_rready_o(rready), .m_rdata_i(rdata), .m_rresp_i(rresp),
    .cpl_valid_o(cpl_valid), .cpl_ready_i(cpl_ready), .cpl_tag_o(cpl_tag),
    .cpl_rdata_o(cpl_rdata), .cpl_status_o(cpl_status)
  );

  int total = 0, fails = 0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive_req(input vec_t v);
    req_write = v.wr; req_bar = v.bar; req_vfa = v.vfa; req_pf = v.pf;
    req_vf = v.vf; req_off = v.off; req_len = v.len; req_wdata = v.wdata;
    req_tag = v.tag; req_valid = 1'b1;
  endtask

  task automatic check_cpl(input vec_t v);
    logic [63:0] er;
    er = (v.exp_st == 2'd1 || v.wr) ? 64'h0 : v.rdata;
    chk(cpl_valid === 1'b1, "R8 cpl_valid", 64'(cpl_valid), 64'h1);
    chk(cpl_tag === v.tag, "R7 cpl_tag", 64'(cpl_tag), 64'(v.tag));
    chk(cpl_status === v.exp_st, "R8 cpl_status", 64'(cpl_status), 64'(v.exp_st));
    chk(cpl_rdata === er, "R7 cpl_rdata", cpl_rdata, er);
  endtask

  task automatic run_vec(input vec_t v);
    logic [26:0] ea;
    ea = {v.vfa, v.pf, v.vf, v.off};
    @(negedge clk); drive_req(v);
    @(negedge clk); req_valid = 1'b0;
    chk(req_ready === 1'b0, "R9 ready low after accept", 64'(req_ready), 64'h0);
    if (v.exp_st == 2'd1) begin
      chk(!awvalid && !wvalid && !arvalid, "R1 R2 R3 no AXI on reject",
          64'({awvalid, wvalid, arvalid}), 64'h0);
    end else if (v.wr) begin
      chk(awvalid && wvalid, "R5 aw/w together", 64'({awvalid, wvalid}), 64'h3);
      chk(awaddr === ea, "R4 awaddr", 64'(awaddr), 64'(ea));
      chk(wdata === v.wdata && wstrb === 8'hFF && awprot === 3'b0, "R5 wdata/wstrb/prot",
          wdata, v.wdata);
      awready = 1'b1; wready = 1'b1;
      @(negedge clk); awready = 1'b0; wready = 1'b0;
      chk(!awvalid && !wvalid, "R6 valids drop", 64'({awvalid, wvalid}), 64'h0);
      bvalid = 1'b1; bresp = v.resp;
      @(negedge clk); bvalid = 1'b0;
    end else begin
      chk(arvalid === 1'b1 && arprot === 3'b0, "R7 arvalid", 64'(arvalid), 64'h1);
      chk(araddr === ea, "R4 araddr", 64'(araddr), 64'(ea));
      arready = 1'b1;
      @(negedge clk); arready = 1'b0;
      chk(!arvalid && rready, "R7 ar done, rready", 64'({arvalid, rready}), 64'h1);
      rvalid = 1'b1; rresp = v.resp; rdata = v.rdata;
      @(negedge clk); rvalid = 1'b0;
    end
    check_cpl(v);
    cpl_ready = 1'b1;
    @(negedge clk); cpl_ready = 1'b0;
    chk(req_ready === 1'b1 && !cpl_valid, "R9 ready after cpl", 64'(req_ready), 64'h1);
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    vec_t d;
    repeat (3) @(negedge clk);
    chk(req_ready === 1'b1, "R11 reset ready", 64'(req_ready), 64'h1);
    chk({awvalid, wvalid, arvalid, bready, rready, cpl_valid} === 6'b0, "R11 reset valids",
        64'({awvalid, wvalid, arvalid, bready, rready, cpl_valid}), 64'h0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) run_vec(VEC[i]);

    // R6: AW accepted before W, B held off until both done
    d = VEC[0]; d.tag = 8'h21; d.wdata = 64'h5555AAAA5555AAAA;
    @(negedge clk); drive_req(d);
    @(negedge clk); req_valid = 1'b0; awready = 1'b1;
    @(negedge clk); awready = 1'b0;
    chk(!awvalid && wvalid, "R6 aw drops alone", 64'({awvalid, wvalid}), 64'h1);
    chk(wdata === d.wdata && bready === 1'b0, "R6 w held, no bready", wdata, d.wdata);
    @(negedge clk);
    chk(wvalid === 1'b1, "R6 w still held", 64'(wvalid), 64'h1);
    wready = 1'b1;
    @(negedge clk); wready = 1'b0;
    chk(!wvalid && bready, "R6 w done, bready", 64'({wvalid, bready}), 64'h1);
    bvalid = 1'b1; bresp = 2'b00;
    @(negedge clk); bvalid = 1'b0;

    // R10/R9: completion stalled while a second request waits
    req_write = 1'b0; req_bar = 3'd2; req_len = 8'd8; req_off = 22'h8; req_tag = 8'h77;
    req_valid = 1'b1;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(cpl_valid && cpl_tag === 8'h21 && cpl_status === 2'd0 && cpl_rdata === 64'h0,
          "R10 cpl held", 64'(cpl_tag), 64'h21);
      chk(req_ready === 1'b0 && !arvalid, "R9 second req refused", 64'(req_ready), 64'h0);
    end
    req_valid = 1'b0; cpl_ready = 1'b1;
    @(negedge clk); cpl_ready = 1'b0;
    @(negedge clk);
    chk(req_ready === 1'b1 && !arvalid && !cpl_valid, "R9 refused req not taken",
        64'({req_ready, arvalid, cpl_valid}), 64'h4);

    summary();
  end
endmodule